// File: doc/BRIEF.md
# Unsigned Integer to Floating-Point Converter

This block turns an unsigned integer operand into a packed binary floating-point value. The source is either a 32-bit or a 64-bit unsigned integer, and the destination is either single precision (8-bit exponent, 23-bit fraction) or double precision (11-bit exponent, 52-bit fraction). That gives four conversions, chosen per operation by two select inputs. Each accepted operation returns its result exactly one clock later, together with a one-cycle inexact strobe.

The operand has no sign, so the result is always positive. Conversion first locates the highest set bit, which may be in either 32-bit half of the source. The operand is then shifted so that this bit drops off the top as the hidden one. The bits below it become the fraction, and the bits that do not fit the fraction are used to round. Since the value is never negative, the directed rounding modes reduce to a choice between incrementing and truncating. When a result is inexact, the caller either gets a strobe that sets a sticky status flag, or, if the trap is enabled, an exception strobe. In both cases the rounded result is delivered.

Top module: `u2f_convert`

## Requirements
- R1: An operand whose effective value is zero gives the all-zero result (positive zero), with neither inexact strobe set.
- R2: The biased exponent is the bias (127 single, 1023 double) plus the bit index of the most significant set bit, counted from bit 0 of the full 64-bit operand. A wide operand whose upper word is zero is therefore handled with an offset-free index taken from its lower word.
- R3: The fraction field holds the bits below the leading one, left-aligned. The leading one itself is not stored.
- R4: A 32-bit source converted to double precision is exact: no rounding and no inexact strobe, whatever the mode and trap settings.
- R5: Rounding mode 2'b00 rounds to nearest with ties to even. It increments when the first dropped bit is 1 and either a lower dropped bit or the kept LSB is 1.
- R6: Rounding mode 2'b10 (toward plus infinity) increments the packed result by one unit in the last place whenever any dropped bit is 1. A fraction carry spills into the exponent field.
- R7: Rounding modes 2'b01 (toward zero) and 2'b11 (toward minus infinity) both keep the truncated result.
- R8: An inexact result with trap_en low pulses inexact_set. With trap_en high it pulses inexact_trap instead. The two strobes are never high together, and the rounded result is delivered in both cases.
- R9: When op_wide is 0, op_value[63:32] has no effect on the result or the strobes.
- R10: out_valid is high exactly in the cycle after each cycle with in_valid high. A single-precision result sits in result[31:0], and result[63:32] is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| in_valid | input | 1 | Operation accepted this cycle |
| op_value | input | 64 | Unsigned integer operand; only bits 31:0 used when op_wide is 0 |
| op_wide | input | 1 | 1: 64-bit source, 0: 32-bit source |
| dst_double | input | 1 | 1: double-precision result, 0: single-precision result |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| trap_en | input | 1 | Inexact results raise inexact_trap instead of inexact_set |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 64 | Packed floating-point result |
| inexact_set | output | 1 | Pulse: set the sticky inexact flag |
| inexact_trap | output | 1 | Pulse: inexact exception |

## Verification
The bench builds the block with its default parameters: 32-bit words, an 8/23 single format and an 11/52 double format. With these values every operand width and format combination can be driven, including leading ones at bit 0, bit 31, bit 32 and bit 63. At this size, fraction carries into the exponent and exact ties at the single-precision guard position can be produced with easy-to-read operands such as all ones and 2^24+1. Random operands are shifted right by random amounts, so that the leading one falls at any position. They are compared against an arithmetic remainder-versus-half reference. For wide double-precision nearest rounding, that reference is cross-checked against native real arithmetic.

// File: rtl/u2f_pkg.sv
package u2f_pkg;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_ZERO    = 2'b01,
    RND_UP      = 2'b10,
    RND_DOWN    = 2'b11
  } rnd_mode_e;

endpackage

// File: rtl/u2f_msb_find.sv
module u2f_msb_find #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 2,
  localparam int VEC_W    = WORD_W * NUM_WORDS,
  localparam int IDX_W    = $clog2(VEC_W),
  localparam int SUB_W    = $clog2(WORD_W)
) (
  input  logic [VEC_W-1:0] vec,
  output logic [IDX_W-1:0] msb_idx,
  output logic             none_set
);

  logic [NUM_WORDS-1:0]            word_any;
  logic [NUM_WORDS-1:0][SUB_W-1:0] word_pos;

  // one priority encoder per word
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] slice;
    logic [SUB_W-1:0]  pos;
    assign slice = vec[w*WORD_W +: WORD_W];
    always_comb begin
      pos = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (slice[b]) pos = SUB_W'(b);
      end
    end
    assign word_any[w] = |slice;
    assign word_pos[w] = pos;
  end

  // the highest nonzero word wins, its base offset is added
  always_comb begin
    msb_idx = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (word_any[w]) msb_idx = IDX_W'(w * WORD_W) + IDX_W'(word_pos[w]);
    end
  end

  assign none_set = ~|word_any;

  always_comb begin
    if (!none_set) begin
      // R2
      msb_pos_chk: assert ((vec >> msb_idx) == VEC_W'(1))
        else $error("leading-one index does not point at the top set bit");
    end
  end

endmodule

// File: rtl/u2f_round_pack.sv
module u2f_round_pack
  import u2f_pkg::*;
#(
  parameter int EXP_W    = 8,
  parameter int FRAC_W   = 23,
  parameter int SRC_W    = 64,
  localparam int IDX_W   = $clog2(SRC_W),
  localparam int OUT_W   = 1 + EXP_W + FRAC_W,
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1,
  localparam int DROP_W  = SRC_W - 1 - FRAC_W
) (
  input  logic [SRC_W-1:0] src,
  input  logic [IDX_W-1:0] msb_idx,
  input  rnd_mode_e        mode,
  output logic [OUT_W-1:0] packed_res,
  output logic             inexact
);

  logic [IDX_W-1:0]  shamt;
  logic [SRC_W-2:0]  below;
  logic [FRAC_W-1:0] frac_t;
  logic [EXP_W-1:0]  exp_f;
  logic              guard;
  logic              sticky;
  logic              inc;

  always_comb begin
    shamt   = IDX_W'(SRC_W - 1) - msb_idx;
    // leading one moves to bit SRC_W-1 and is cut off as the hidden bit
    below   = (SRC_W - 1)'(src << shamt);
    frac_t  = below[SRC_W-2 -: FRAC_W];
    guard   = below[DROP_W-1];
    sticky  = |below[DROP_W-2:0];
    exp_f   = EXP_W'(BIAS) + EXP_W'(msb_idx);
    inexact = guard | sticky;
    unique case (mode)
      RND_NEAREST: inc = guard & (sticky | frac_t[0]);
      RND_UP:      inc = inexact;
      default:     inc = 1'b0;
    endcase
    // a carry out of the fraction walks into the exponent
    packed_res = {1'b0, exp_f, frac_t} + OUT_W'(inc);
  end

endmodule

// File: rtl/u2f_convert.sv
module u2f_convert
  import u2f_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int SGL_EXP_W  = 8,
  parameter int SGL_FRAC_W = 23,
  parameter int DBL_EXP_W  = 11,
  parameter int DBL_FRAC_W = 52,
  localparam int SRC_W     = 2 * WORD_W,
  localparam int IDX_W     = $clog2(SRC_W),
  localparam int SGL_W     = 1 + SGL_EXP_W + SGL_FRAC_W,
  localparam int RES_W     = 1 + DBL_EXP_W + DBL_FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [SRC_W-1:0] op_value,
  input  logic             op_wide,
  input  logic             dst_double,
  input  logic [1:0]       rnd_mode,
  input  logic             trap_en,
  output logic             out_valid,
  output logic [RES_W-1:0] result,
  output logic             inexact_set,
  output logic             inexact_trap
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta;
  logic rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // operand select and leading-one search
  logic [SRC_W-1:0] src_eff;
  logic [IDX_W-1:0] msb_idx;
  logic             is_zero;

  assign src_eff = op_wide ? op_value : {{WORD_W{1'b0}}, op_value[WORD_W-1:0]};

  u2f_msb_find #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (2)
  ) i_msb_find (
    .vec      (src_eff),
    .msb_idx  (msb_idx),
    .none_set (is_zero)
  );

  // one rounder per destination format
  logic [SGL_W-1:0] sgl_res;
  logic [RES_W-1:0] dbl_res;
  logic             sgl_inx;
  logic             dbl_inx;

  u2f_round_pack #(
    .EXP_W  (SGL_EXP_W),
    .FRAC_W (SGL_FRAC_W),
    .SRC_W  (SRC_W)
  ) i_round_sgl (
    .src        (src_eff),
    .msb_idx    (msb_idx),
    .mode       (rnd_mode_e'(rnd_mode)),
    .packed_res (sgl_res),
    .inexact    (sgl_inx)
  );

  u2f_round_pack #(
    .EXP_W  (DBL_EXP_W),
    .FRAC_W (DBL_FRAC_W),
    .SRC_W  (SRC_W)
  ) i_round_dbl (
    .src        (src_eff),
    .msb_idx    (msb_idx),
    .mode       (rnd_mode_e'(rnd_mode)),
    .packed_res (dbl_res),
    .inexact    (dbl_inx)
  );

  // next state
  logic [RES_W-1:0] result_d;
  logic             inexact_d;
  logic             set_d;
  logic             trap_d;

  always_comb begin
    inexact_d = ~is_zero & (dst_double ? dbl_inx : sgl_inx);
    if (is_zero)         result_d = '0;
    else if (dst_double) result_d = dbl_res;
    else                 result_d = RES_W'(sgl_res);
    set_d  = in_valid & inexact_d & ~trap_en;
    trap_d = in_valid & inexact_d & trap_en;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid    <= 1'b0;
      inexact_set  <= 1'b0;
      inexact_trap <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      inexact_set  <= set_d;
      inexact_trap <= trap_d;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      result <= result_d;
    end
  end

  // R1
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && src_eff == '0) |=> (result == '0 && !inexact_set && !inexact_trap));

  // R4
  narrow_dbl_exact_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && !op_wide && dst_double) |=> (!inexact_set && !inexact_trap));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({inexact_set, inexact_trap}));

  // R8
  strobe_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (inexact_set || inexact_trap) |-> out_valid);

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);

  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> !out_valid);

  // R10
  single_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (in_valid && !dst_double) |=> (result[RES_W-1:SGL_W] == '0));

endmodule

// File: tb/test_u2f_convert.sv
module test_u2f_convert;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] op_value;
  logic        op_wide;
  logic        dst_double;
  logic [1:0]  rnd_mode;
  logic        trap_en;
  logic        out_valid;
  logic [63:0] result;
  logic        inexact_set;
  logic        inexact_trap;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  u2f_convert i_u2f_convert (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .op_value     (op_value),
    .op_wide      (op_wide),
    .dst_double   (dst_double),
    .rnd_mode     (rnd_mode),
    .trap_en      (trap_en),
    .out_valid    (out_valid),
    .result       (result),
    .inexact_set  (inexact_set),
    .inexact_trap (inexact_trap)
  );

  typedef struct {
    logic [63:0] res;
    bit          set;
    bit          trp;
    string       tag;
  } exp_item_t;

  exp_item_t sb_q[$];

  // arithmetic reference: remainder compared with half a unit
  function automatic logic [63:0] ref_conv(input logic [63:0] op, input bit wide,
                                           input bit dbl, input logic [1:0] mode,
                                           output bit inx);
    logic [63:0] v, sig, rem, half;
    int m, f, bias, sh, e;
    bit inc;
    v = wide ? op : {32'd0, op[31:0]};
    inx = 0;
    if (v == 0) return 64'd0;
    m = 0;
    for (int b = 0; b < 64; b++) if (v[b]) m = b;
    f    = dbl ? 52 : 23;
    bias = dbl ? 1023 : 127;
    if (m <= f) begin
      sig = v << (f - m); rem = 0; half = 0;
    end else begin
      sh = m - f; sig = v >> sh; rem = v - (sig << sh); half = 64'd1 << (sh - 1);
    end
    inx = (rem != 0);
    inc = 0;
    if (mode == 2'b00) inc = (rem > half) || (rem != 0 && rem == half && sig[0]);
    else if (mode == 2'b10) inc = inx;
    sig = sig + 64'(inc);
    e = m;
    if (sig == (64'd1 << (f + 1))) begin sig = sig >> 1; e++; end
    if (dbl) return {1'b0, 11'(bias + e), sig[51:0]};
    return {32'd0, 1'b0, 8'(bias + e), sig[22:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic push_drive(input logic [63:0] op, input bit wide, input bit dbl,
                            input logic [1:0] mode, input bit trp,
                            input logic [63:0] res, input bit inx, input string tag);
    exp_item_t it;
    it.res = res; it.set = inx & !trp; it.trp = inx & trp; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    in_valid = 1'b1; op_value = op; op_wide = wide; dst_double = dbl;
    rnd_mode = mode; trap_en = trp;
  endtask

  task automatic send(input logic [63:0] op, input bit wide, input bit dbl,
                      input logic [1:0] mode, input bit trp, input string tag);
    bit inx;
    logic [63:0] r;
    r = ref_conv(op, wide, dbl, mode, inx);
    push_drive(op, wide, dbl, mode, trp, r, inx, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops one expected item per valid output
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb_q.size() == 0) begin
        check(0, "R10 unexpected out_valid", 64'd1, 64'd0);
      end else begin
        exp_item_t it;
        it = sb_q.pop_front();
        check(result == it.res, {it.tag, " result"}, result, it.res);
        check({inexact_set, inexact_trap} == {it.set, it.trp}, {it.tag, " R8 strobes"},
              64'({inexact_set, inexact_trap}), 64'({it.set, it.trp}));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_value = '0; op_wide = 1'b0;
    dst_double = 1'b0; rnd_mode = 2'b00; trap_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0 && inexact_set == 1'b0 && inexact_trap == 1'b0,
          "R10 reset state", 64'({out_valid, inexact_set, inexact_trap}), 64'd0);

    // R1 zero in all shapes, R9 narrow ignores upper word
    push_drive(64'd0, 0, 0, 2'b10, 0, 64'd0, 0, "R1 zero narrow single");
    push_drive(64'd0, 1, 1, 2'b00, 1, 64'd0, 0, "R1 zero wide double");
    push_drive(64'hDEADBEEF_00000000, 0, 0, 2'b10, 0, 64'd0, 0, "R9 R1 narrow garbage upper");
    push_drive(64'hDEADBEEF_00000001, 0, 0, 2'b00, 0, 64'h3F800000, 0, "R9 narrow one");
    // R2 exponent positions
    push_drive(64'd1, 1, 1, 2'b00, 0, 64'h3FF0000000000000, 0, "R2 one double");
    push_drive(64'h80000000, 0, 0, 2'b00, 0, 64'h4F000000, 0, "R2 bit31 single");
    push_drive(64'h8000000000000000, 1, 1, 2'b00, 0, 64'h43E0000000000000, 0, "R2 bit63 double");
    push_drive(64'd5, 1, 0, 2'b00, 0, 64'h40A00000, 0, "R2 wide upper zero");
    push_drive(64'h0000000100000000, 1, 0, 2'b00, 0, 64'h4F800000, 0, "R2 bit32 single");
    // R3 fraction
    push_drive(64'h00FFFFFF, 0, 0, 2'b10, 0, 64'h4B7FFFFF, 0, "R3 full fraction exact");
    // R4 narrow to double exact
    push_drive(64'hFFFFFFFF, 0, 1, 2'b10, 1, 64'h41EFFFFFFFE00000, 0, "R4 narrow double exact");
    // R5 nearest, ties to even
    push_drive(64'h01000001, 0, 0, 2'b00, 0, 64'h4B800000, 1, "R5 tie even stays");
    push_drive(64'h01000003, 0, 0, 2'b00, 0, 64'h4B800002, 1, "R5 tie odd rounds up");
    push_drive(64'hFFFFFFFF, 0, 0, 2'b00, 0, 64'h4F800000, 1, "R5 nearest carry");
    push_drive(64'hFFFFFFFFFFFFFFFF, 1, 1, 2'b00, 0, 64'h43F0000000000000, 1, "R5 wide double carry");
    // R6 toward +inf
    push_drive(64'hFFFFFFFF, 0, 0, 2'b10, 0, 64'h4F800000, 1, "R6 up carry into exponent");
    push_drive(64'h01000001, 0, 0, 2'b10, 0, 64'h4B800001, 1, "R6 up small remainder");
    // R7 truncating modes
    push_drive(64'hFFFFFFFF, 0, 0, 2'b01, 0, 64'h4F7FFFFF, 1, "R7 toward zero");
    push_drive(64'hFFFFFFFF, 0, 0, 2'b11, 0, 64'h4F7FFFFF, 1, "R7 toward minus");
    push_drive(64'hFFFFFFFFFFFFFFFF, 1, 1, 2'b01, 0, 64'h43EFFFFFFFFFFFFF, 1, "R7 wide double trunc");
    // R8 trap
    push_drive(64'hFFFFFFFF, 0, 0, 2'b01, 1, 64'h4F7FFFFF, 1, "R8 trap inexact");
    push_drive(64'hFFFFFFFF, 0, 0, 2'b10, 1, 64'h4F800000, 1, "R8 trap rounded result");
    push_drive(64'd1, 0, 0, 2'b00, 1, 64'h3F800000, 0, "R8 trap exact quiet");
    idle(3);
    check(out_valid == 1'b0, "R10 idle no valid", 64'(out_valid), 64'd0);

    // random operands, all four variants
    for (int n = 0; n < 1500; n++) begin
      logic [63:0] op;
      bit wide, dbl, trp;
      logic [1:0] mode;
      op   = {$urandom, $urandom} >> ($urandom % 64);
      wide = 1'($urandom); dbl = 1'($urandom); trp = 1'($urandom);
      mode = 2'($urandom);
      if (wide && dbl && mode == 2'b00) begin
        bit inx;
        logic [63:0] r, rr;
        real x;
        r  = ref_conv(op, 1, 1, 2'b00, inx);
        x  = real'(op[63:32]) * 4294967296.0 + real'(op[31:0]);
        rr = $realtobits(x);
        check(r == rr, "R5 reference versus real", r, rr);
      end
      if (n % 7 == 3) idle(1);
      send(op, wide, dbl, mode, trp, "R2 R3 R5 R6 R7 random");
    end
    idle(4);
    check(sb_q.size() == 0, "R10 all results returned", 64'(sb_q.size()), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule